// File: doc/BRIEF.md
# ADC Autoscan Sequence Controller

This block is the digital sequencer that walks an eight-input analog-to-digital converter core through a scan of its channels. Software programs an 8-bit control register. Its fields give the first channel of the scan, enable the two hardware triggers, gate power, choose single or continuous operation and hold a run bit. When the run bit is set and power is on, the controller selects a channel, pulses a start strobe to the core and waits for the core's done pulse. It then stores the result in that channel's data register and moves to the next channel. The scan ends after channel 7.

A scan can be launched in three ways: software sets the run bit, a falling edge appears on the asynchronous active-low external trigger pin, or a pulse arrives on the internal timer event. Each trigger has its own enable bit, and the two enabled triggers are ORed. In single mode the hardware clears the run bit when the scan ends. In continuous mode scans follow one another until software clears the bit. Any write to the control register aborts the conversion in flight, and the controller passes that abort to the core. A one-cycle interrupt pulse marks the end of every scan. The stored results can be read at any time through a channel-indexed read port.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the control register reads 00h, and neither the start strobe nor the interrupt is asserted.
- R2: The control register reads back the last written byte. Bits 7:5 are the start channel, bit 4 the external trigger enable, bit 3 the internal trigger enable, bit 2 power-on, bit 1 continuous mode and bit 0 the run bit. Only hardware changes to bit 0 alter this value.
- R3: A scan issues one single-cycle start strobe per channel. The first strobe uses the programmed start channel, and each later strobe uses the previous channel plus one, up to and including channel 7. A start channel of 7 converts channel 7 only.
- R4: A write to the control register raises the abort output in the same cycle and returns the sequencer to idle. No start strobe follows in the next cycle. A scan that begins afterwards starts at the newly written start channel.
- R5: A falling edge on the external trigger pin (when bit 4 is 1) or a timer event pulse (when bit 3 is 1) sets the run bit and starts a scan. A trigger whose enable bit is 0 has no effect.
- R6: In single mode each start produces exactly one scan. The run bit reads 0 from the cycle in which the end-of-scan interrupt is high.
- R7: In continuous mode a new scan starts at the start channel after each channel 7 conversion, with no trigger needed, and the run bit stays 1.
- R8: While the power bit is 0, no start strobe is issued and triggers do not set the run bit.
- R9: A trigger that arrives while a scan is running neither restarts nor extends it.
- R10: Each done pulse stores the conversion result in the register of the converted channel. The interrupt is a one-cycle pulse in the cycle after the channel 7 result is stored.
- R11: When software writes the run bit to 0, the sequencer stays idle. The next scan begins at the programmed start channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| ext_trig_n | input | 1 | Asynchronous active-low external trigger pin |
| tmr_event | input | 1 | Internal timer event pulse, synchronous |
| conv_start | output | 1 | One-cycle start-of-conversion strobe to the core |
| conv_chan | output | 3 | Channel select to the core |
| conv_abort | output | 1 | Abort of the conversion in flight |
| conv_done | input | 1 | One-cycle conversion-complete pulse from the core |
| conv_result | input | RES_W | Conversion result, valid with conv_done |
| rd_chan | input | 3 | Result read channel index |
| rd_data | output | RES_W | Stored result of channel rd_chan |
| seq_done_irq | output | 1 | One-cycle end-of-scan interrupt |

## Verification
The assertions assume that the core raises done only while a conversion it was asked for is pending, and that it drops that conversion when abort is pulsed. Without these assumptions the interrupt could not be traced back to a channel 7 completion. The bench's converter model meets them: it answers every strobe after a fixed latency and cancels its pending answer when it sees abort. External trigger pulses are held low for at least one clock period and spaced wider than the synchronizer. Random trigger times are drawn only inside scans or after the previous scan has ended, so the repetition period always exceeds the scan time.

// File: rtl/adc_scan_pkg.sv
// Package: shared types and field layout of the scan controller.
// Assumes eight analog inputs addressed by a 3-bit channel number.
package adc_scan_pkg;

    localparam int NUM_CH  = 8;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int CTL_W   = 8;

    // Control register; the packed order fixes the bit positions software uses.
    typedef struct packed {
        logic [CH_W-1:0] chan_first;   // bits 7:5
        logic            ext_en;       // bit 4
        logic            tmr_en;       // bit 3
        logic            pwr_on;       // bit 2
        logic            cont_mode;    // bit 1
        logic            run;          // bit 0
    } scan_ctl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_trig_sync.sv
// Synchronizes an asynchronous active-low trigger pin and emits a
// one-cycle pulse for every falling edge. Assumes the pin stays low for
// at least one clock period; the chain resets to the idle (high) level.
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_pulse
);

    logic [STAGES:0] chain_q;

    // Shift the pin through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], pin_n};
    end

    // Edge: previous synchronized level high, current low.
    assign fall_pulse = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/adc_result_bank.sv
// Holds one result register per channel, written on conversion completion,
// read through a combinational channel-indexed port.
module adc_result_bank #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RES_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RES_W-1:0] rd_data
);

    logic [RES_W-1:0] slot_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        // Capture the result when this channel's conversion completes.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    slot_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))         slot_q[g] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/adc_seq_fsm.sv
// Scan sequencer: issues a start strobe per channel from the first channel
// up to the last, waits for the core's done pulse between strobes and
// reports completion. Assumes done arrives only while a conversion is
// pending; an abort returns it to idle at the newly written first channel.
module adc_seq_fsm
    import adc_scan_pkg::*;
#(
    parameter int NUM_CHAN = NUM_CH,
    localparam int IDX_W   = $clog2(NUM_CHAN),
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CHAN - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic [IDX_W-1:0] abort_first,
    input  logic             run,
    input  logic             pwr_on,
    input  logic             cont_mode,
    input  logic [IDX_W-1:0] chan_first,
    input  logic             conv_done,
    output logic             conv_start,
    output logic [IDX_W-1:0] conv_chan,
    output logic             store_en,
    output logic             scan_end,
    output logic             busy
);

    seq_state_e       state_q;
    logic [IDX_W-1:0] chan_q;

    // Qualified completion of the current conversion.
    always_comb begin
        store_en = (state_q == SEQ_WAIT) && conv_done && !abort;
        scan_end = store_en && (chan_q == LAST);
    end

    // State and channel pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            chan_q  <= '0;
        end else if (abort) begin
            state_q <= SEQ_IDLE;
            chan_q  <= abort_first;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    chan_q <= chan_first;
                    if (run && pwr_on) state_q <= SEQ_ISSUE;
                end
                SEQ_ISSUE: state_q <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (store_en) begin
                        if (chan_q != LAST) begin
                            chan_q  <= chan_q + 1'b1;
                            state_q <= SEQ_ISSUE;
                        end else begin
                            chan_q  <= chan_first;
                            state_q <= cont_mode ? SEQ_ISSUE : SEQ_IDLE;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign conv_start = (state_q == SEQ_ISSUE);
    assign conv_chan  = chan_q;
    assign busy       = (state_q != SEQ_IDLE);

endmodule

// File: rtl/adc_scan_ctrl.sv
// Top of the autoscan controller: owns the control register, merges the
// two triggers into the run bit, and ties together the sequencer and the
// result bank. Assumes the core cancels its conversion on conv_abort.
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             ext_trig_n,
    input  logic             tmr_event,
    output logic             conv_start,
    output logic [2:0]       conv_chan,
    output logic             conv_abort,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic [2:0]       rd_chan,
    output logic [RES_W-1:0] rd_data,
    output logic             seq_done_irq
);

    scan_ctl_t ctl_q;
    scan_ctl_t wr_ctl;
    logic      ext_fall;
    logic      trig_hit;
    logic      trig_set;
    logic      store_en;
    logic      scan_end;
    logic      busy;
    logic      irq_q;

    assign wr_ctl = scan_ctl_t'(cfg_wdata);

    adc_trig_sync #(
        .STAGES (SYNC_STAGES)
    ) u_ext_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (ext_trig_n),
        .fall_pulse (ext_fall)
    );

    // Enabled triggers are ORed; they only count when powered and idle.
    always_comb begin
        trig_hit = (ext_fall & ctl_q.ext_en) | (tmr_event & ctl_q.tmr_en);
        trig_set = trig_hit && ctl_q.pwr_on && !busy;
    end

    // Control register: software write wins, then hardware clear/set of run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (cfg_wr) begin
            ctl_q <= wr_ctl;
        end else if (scan_end && !ctl_q.cont_mode) begin
            ctl_q.run <= 1'b0;
        end else if (trig_set) begin
            ctl_q.run <= 1'b1;
        end
    end

    adc_seq_fsm #(
        .NUM_CHAN (NUM_CH)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (cfg_wr),
        .abort_first (wr_ctl.chan_first),
        .run         (ctl_q.run),
        .pwr_on      (ctl_q.pwr_on),
        .cont_mode   (ctl_q.cont_mode),
        .chan_first  (ctl_q.chan_first),
        .conv_done   (conv_done),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .store_en    (store_en),
        .scan_end    (scan_end),
        .busy        (busy)
    );

    adc_result_bank #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_idx  (conv_chan),
        .wr_data (conv_result),
        .rd_idx  (rd_chan),
        .rd_data (rd_data)
    );

    // End-of-scan interrupt, one cycle after the last result is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= scan_end;
    end

    assign cfg_rdata    = ctl_q;
    assign conv_abort   = cfg_wr;
    assign seq_done_irq = irq_q;

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
// Checker for the autoscan controller, bound to every instance of the top.
// Assumes done pulses are answers to issued strobes and are cancelled on abort.
module adc_scan_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_rdata,
    input logic       conv_start,
    input logic [2:0] conv_chan,
    input logic       conv_done,
    input logic       seq_done_irq
);

    AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);                                       // R3

    AST_CHAN_NOT_BELOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan >= cfg_rdata[7:5]));                     // R3

    AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !conv_start);                                           // R4

    AST_SINGLE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done_irq && !cfg_rdata[1]) |-> !cfg_rdata[0]);                // R6

    AST_NO_START_POWERED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[2] |-> !conv_start);                                    // R8

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_irq |=> !seq_done_irq);                                   // R10

    AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_irq |-> $past(conv_done && conv_chan == 3'd7));           // R10

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk u_scan_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_rdata    (cfg_rdata),
    .conv_start   (conv_start),
    .conv_chan    (conv_chan),
    .conv_done    (conv_done),
    .seq_done_irq (seq_done_irq)
);

// File: tb/test_adc_scan_ctrl.sv
// Bench for the autoscan controller: a fixed-latency converter model,
// directed corner cases, then seeded random trigger scans.
module test_adc_scan_ctrl;

    localparam int RES_W = 10;
    localparam int LAT   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [7:0]       cfg_wdata = '0;
    logic [7:0]       cfg_rdata;
    logic             ext_trig_n = 1'b1;
    logic             tmr_event = 1'b0;
    logic             conv_start;
    logic [2:0]       conv_chan;
    logic             conv_abort;
    logic             conv_done = 1'b0;
    logic [RES_W-1:0] conv_result = '0;
    logic [2:0]       rd_chan = '0;
    logic [RES_W-1:0] rd_data;
    logic             seq_done_irq;

    int n_chk = 0, n_fail = 0;
    int n_starts = 0, n_irq = 0, cycles = 0;
    int exp_next = 0, pend = 0, cur = 0, tally = 0;
    logic [7:0]       ctl_sh = '0;
    logic [RES_W-1:0] exp_res [8];

    always #2 clk = ~clk;

    adc_scan_ctrl #(.RES_W(RES_W)) i_adc_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ext_trig_n(ext_trig_n), .tmr_event(tmr_event),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_abort(conv_abort),
        .conv_done(conv_done), .conv_result(conv_result), .rd_chan(rd_chan),
        .rd_data(rd_data), .seq_done_irq(seq_done_irq));

    function automatic logic [RES_W-1:0] res_of(int ch, int t);
        return RES_W'(ch * 97 + t * 13 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model and monitors, sampled on the falling edge.
    always @(negedge clk) begin
        cycles++;
        conv_done = 1'b0;
        if (seq_done_irq) n_irq++;
        if (conv_abort) begin
            pend = 0;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                conv_done   = 1'b1;
                conv_result = res_of(cur, tally);
                exp_res[cur] = conv_result;
                tally++;
                exp_next = (cur == 7) ? int'(ctl_sh[7:5]) : cur + 1;
            end
        end
        if (conv_start) begin
            chk(int'(conv_chan) == exp_next, "R3 channel order", int'(conv_chan), exp_next);
            cur  = int'(conv_chan);
            pend = LAT;
            n_starts++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; ctl_sh = v; exp_next = int'(v[7:5]);
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic clr_counts();
        n_starts = 0; n_irq = 0;
    endtask

    task automatic wait_irq(input int n, input int lim);
        for (int i = 0; i < lim && n_irq < n; i++) step(1);
    endtask

    task automatic ext_pulse();
        ext_trig_n = 1'b0; step(1); ext_trig_n = 1'b1;
    endtask

    task automatic tmr_pulse();
        tmr_event = 1'b1; step(1); tmr_event = 1'b0;
    endtask

    task automatic chk_results(input int first);
        for (int ch = first; ch < 8; ch++) begin
            rd_chan = 3'(ch); #1;
            chk(rd_data == exp_res[ch], "R10 stored result", int'(rd_data), int'(exp_res[ch]));
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) if (cycles > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5CA1_0E11));
        for (int i = 0; i < 8; i++) exp_res[i] = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        chk(cfg_rdata == 8'h00, "R1 ctl reset", int'(cfg_rdata), 0);
        chk(!conv_start && !seq_done_irq, "R1 outputs idle", int'(conv_start), 0);

        // R2/R6/R10: single scan from channel 5
        clr_counts();
        wr(8'b101_00_1_0_1);
        wait_irq(1, 200); step(20);
        chk(n_starts == 3, "R6 one scan 5..7", n_starts, 3);
        chk(n_irq == 1, "R10 one interrupt", n_irq, 1);
        chk(cfg_rdata == 8'b101_00_1_0_0, "R2 R6 readback run cleared", int'(cfg_rdata), 'hA4);
        chk_results(5);

        // R3: start channel 7 converts only channel 7
        clr_counts();
        wr(8'b111_00_1_0_1);
        wait_irq(1, 200); step(20);
        chk(n_starts == 1, "R3 only channel 7", n_starts, 1);

        // R8: powered down, run set, trigger enabled: nothing happens
        clr_counts();
        wr(8'b000_11_0_0_1);
        step(10); ext_pulse(); tmr_pulse(); step(40);
        chk(n_starts == 0, "R8 no strobe powered down", n_starts, 0);
        chk(cfg_rdata == 8'b000_11_0_0_1, "R2 R8 readback", int'(cfg_rdata), 'h19);
        wr(8'b000_11_0_0_0); ext_pulse(); step(20);
        chk(cfg_rdata[0] == 1'b0, "R8 trigger ignored powered down", int'(cfg_rdata[0]), 0);

        // R5: disabled timer event has no effect; enabled external edge starts
        clr_counts();
        wr(8'b100_10_1_0_0);
        tmr_pulse(); step(30);
        chk(n_starts == 0 && cfg_rdata[0] == 1'b0, "R5 disabled trigger ignored", n_starts, 0);
        ext_pulse();
        wait_irq(1, 200); step(20);
        chk(n_starts == 4, "R5 external trigger scan", n_starts, 4);
        chk(n_irq == 1, "R5 external one interrupt", n_irq, 1);
        clr_counts();
        wr(8'b010_01_1_0_0);
        tmr_pulse();
        wait_irq(1, 200); step(20);
        chk(n_starts == 6, "R5 timer trigger scan", n_starts, 6);

        // R9: triggers during a running scan are ignored
        clr_counts();
        wr(8'b000_11_1_0_0);
        ext_pulse();
        step(12); tmr_pulse(); step(6); ext_pulse();
        wait_irq(1, 300); step(30);
        chk(n_starts == 8, "R9 scan not extended", n_starts, 8);
        chk(n_irq == 1, "R9 scan not restarted", n_irq, 1);
        chk_results(0);

        // R7: continuous mode runs back to back; R11: clearing run stops it
        clr_counts();
        wr(8'b110_00_1_1_1);
        wait_irq(3, 400);
        chk(n_irq >= 3, "R7 repeated scans", n_irq, 3);
        chk(cfg_rdata[0] == 1'b1, "R7 run stays set", int'(cfg_rdata[0]), 1);
        wr(8'b110_00_1_1_0);
        clr_counts(); step(60);
        chk(n_starts == 0, "R11 idle after run cleared", n_starts, 0);
        wr(8'b110_00_1_0_1);
        wait_irq(1, 200); step(10);
        chk(n_starts == 2, "R11 restart at first channel", n_starts, 2);

        // R4: write in mid-scan aborts and restarts at the new first channel
        clr_counts();
        wr(8'b000_00_1_0_1);
        for (int i = 0; i < 200 && n_starts < 3; i++) step(1);
        step(2);
        clr_counts();
        wr(8'b010_00_1_0_1);
        chk(conv_start == 1'b0, "R4 no strobe after write", int'(conv_start), 0);
        wait_irq(1, 300); step(20);
        chk(n_starts == 6, "R4 restarted scan 2..7", n_starts, 6);
        chk(n_irq == 1, "R4 single interrupt", n_irq, 1);

        // Random: seeded first channel and trigger source, single mode
        for (int it = 0; it < 24; it++) begin
            int sc  = int'($urandom_range(0, 7));
            bit ext = 1'($urandom_range(0, 1));
            clr_counts();
            wr({3'(sc), ext, !ext, 1'b1, 1'b0, 1'b0});
            step(int'($urandom_range(1, 6)));
            if (ext) ext_pulse(); else tmr_pulse();
            if ($urandom_range(0, 1) == 1) begin
                step(int'($urandom_range(1, 4)));
                if (ext) ext_pulse(); else tmr_pulse();
            end
            wait_irq(1, 300); step(25);
            chk(n_starts == 8 - sc, "R3 R5 random scan length", n_starts, 8 - sc);
            chk(n_irq == 1, "R6 R9 random one interrupt", n_irq, 1);
            chk(cfg_rdata[0] == 1'b0, "R6 random run cleared", int'(cfg_rdata[0]), 0);
        end
        chk_results(0);

        finish_run();
    end

endmodule